// File: doc/BRIEF.md
# Cascadable CAM Device-Select Controller

This block is the command-side selection logic for one content-addressable memory device in a daisy chain of such devices that share one 16-bit bus. It keeps three pieces of state: a device-select word, a page-address word and a full flag. From these it decides whether its device takes part in register writes, in the set-full instruction and in reads.

Bus traffic comes in two cycle kinds. A command write either names a target register or carries the set-full instruction. A data write then loads the named register. A device-select value of all ones makes every device in the chain accept writes at once. In that broadcast state, only a device that reports a match may drive reads. A device can also be selected on its own, by making the device-select value equal to its page address.

The full flag is passed down the chain. Each set-full instruction fills the first device that is still empty and whose predecessor is already full. Only that device may take a new page address, which is how each device in the chain gets its own page address. The match array, the priority between chips and the data RAM sit outside this block. The match state arrives as one input bit.

Top module: `cam_sel_ctrl`

## Requirements
- R1: A low level on `rst_n` drives `full_n`, `casc_full_n` and `rd_en_n` high, sets the device-select word to all ones, and sets the page address to `PA_INIT` (default 0).
- R2: A command write is a cycle with `ce_n`, `cmd_n` and `we_n` all low. A data write is a cycle with `ce_n` low, `cmd_n` high and `we_n` low. A data write acts only on the target named by the latest command, and it clears that target. Data writes with no pending target, and any cycle with `ce_n` high, change nothing.
- R3: The device is selected when the device-select word is all ones or equals the page address. A device that is not selected ignores every data write and every set-full instruction.
- R4: The target-register command is the word `{8'h02, 6'b0, t}`, with t = 0 for control, 1 for device select and 2 for page address. A page-address write takes effect only while the predecessor is full and the local flag is clear. The value all ones is never accepted as a page address.
- R5: The set-full instruction is exactly the word `16'h0700`. A selected device sets its full flag on it only while its predecessor is full and its own flag is clear. `full_n` goes low after that edge.
- R6: A data write of `0000` to the control target clears the full flag and leaves the page address and the device-select word unchanged. A control write with any other value has no effect.
- R7: `casc_full_n` is registered. It is low only when the local full flag and the predecessor's full state (`prev_full_n` low) are both set at the same edge.
- R8: `rd_en_n` is registered. It goes low one cycle after the device-select word equals the page address, or after the word is all ones while `match_in` is high. Otherwise it is high.
- R9: Once set, the full flag stays set until a control reset or `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Hardware reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| cmd_n | input | 1 | Low for command cycles, high for data cycles |
| we_n | input | 1 | Write strobe, active low |
| bus | input | DW | Shared data/command bus |
| prev_full_n | input | 1 | Full state of the previous device, active low; tied low on the first device |
| match_in | input | 1 | Match status from the local array, active high |
| full_n | output | 1 | Local full flag, active low, registered |
| casc_full_n | output | 1 | Full output to the next device, active low, registered |
| rd_en_n | output | 1 | Read permission, active low, registered |

## Verification
The selection rule is tried with three device-select patterns. The broadcast value with and without `match_in` shows that a match opens reads. A value equal to the page address opens reads without a match. A value that matches neither leaves the device deaf, so a later write of all ones to the device-select register cannot recover it. The chain condition is tried with `prev_full_n` both high and low around page-address writes and set-full instructions. Because the bench reads the page address back through the read gate, it can tell an accepted page-address write from a rejected one. Control writes of zero and non-zero data, a data write with no pending target, and a command with `ce_n` high separate the real reset path from stray traffic.

// File: rtl/cam_sel_pkg.sv
package cam_sel_pkg;

   localparam int TGT_W = 2;

   typedef enum logic [TGT_W-1:0] {
      TGT_CTRL = 2'd0,
      TGT_DSEL = 2'd1,
      TGT_PAGE = 2'd2,
      TGT_NONE = 2'd3
   } tgt_e;

   typedef enum logic [1:0] {
      CYC_IDLE    = 2'd0,
      CYC_CMD_WR  = 2'd1,
      CYC_DATA_WR = 2'd2,
      CYC_READ    = 2'd3
   } cyc_e;

endpackage

// File: rtl/cam_cmd_decode.sv
module cam_cmd_decode
   import cam_sel_pkg::*;
#(
   parameter int              DW         = 16,
   parameter int              OPW        = 8,
   parameter logic [OPW-1:0]  OP_TARGET  = 'h02,
   parameter logic [OPW-1:0]  OP_SETFULL = 'h07
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          cmd_n,
   input  logic          we_n,
   input  logic [DW-1:0] bus,
   output logic          data_wr,
   output logic          sff_cmd,
   output tgt_e          tgt
);

   localparam int MIDW = DW - OPW - TGT_W;

   cyc_e             cyc;
   logic [OPW-1:0]   op;
   logic [MIDW-1:0]  mid;
   logic [TGT_W-1:0] tsel;
   logic             cmd_wr;
   logic             is_target;

   always_comb begin
      if (ce_n)            cyc = CYC_IDLE;
      else if (we_n)       cyc = CYC_READ;
      else if (!cmd_n)     cyc = CYC_CMD_WR;
      else                 cyc = CYC_DATA_WR;
      cmd_wr    = (cyc == CYC_CMD_WR);
      data_wr   = (cyc == CYC_DATA_WR);
      op        = bus[DW-1 -: OPW];
      mid       = bus[TGT_W +: MIDW];
      tsel      = bus[TGT_W-1:0];
      is_target = cmd_wr && (op == OP_TARGET) && (mid == '0);
      sff_cmd   = cmd_wr && (op == OP_SETFULL) && (mid == '0) && (tsel == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tgt <= TGT_NONE;
      else if (is_target)
         tgt <= tgt_e'(tsel);
      else if (cmd_wr || data_wr)
         tgt <= TGT_NONE;
   end

endmodule

// File: rtl/cam_sel_regs.sv
module cam_sel_regs
   import cam_sel_pkg::*;
#(
   parameter int             DW      = 16,
   parameter logic [DW-1:0]  PA_INIT = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          data_wr,
   input  tgt_e          tgt,
   input  logic [DW-1:0] bus,
   input  logic          chain_active,
   output logic [DW-1:0] ds_q,
   output logic [DW-1:0] pa_q,
   output logic          dev_sel,
   output logic          soft_rst
);

   localparam logic [DW-1:0] ALL_ONES = '1;

   logic wr_ok;
   logic ds_we;
   logic pa_we;

   always_comb begin
      dev_sel  = (ds_q == ALL_ONES) || (ds_q == pa_q);
      wr_ok    = data_wr && dev_sel;
      ds_we    = wr_ok && (tgt == TGT_DSEL);
      pa_we    = wr_ok && (tgt == TGT_PAGE) && chain_active && (bus != ALL_ONES);
      soft_rst = wr_ok && (tgt == TGT_CTRL) && (bus == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ds_q <= ALL_ONES;
      else if (ds_we)
         ds_q <= bus;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pa_q <= PA_INIT;
      else if (pa_we)
         pa_q <= bus;
   end

endmodule

// File: rtl/cam_full_chain.sv
module cam_full_chain #(
   parameter bit CHAIN_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic sff_cmd,
   input  logic dev_sel,
   input  logic prev_full_n,
   output logic chain_active,
   output logic full_n,
   output logic casc_full_n
);

   logic full_q;
   logic full_d;
   logic prev_full;

   generate
      if (CHAIN_EN) begin : g_chain
         assign prev_full = !prev_full_n;
      end else begin : g_alone
         logic unused_prev;
         assign unused_prev = prev_full_n;
         assign prev_full   = 1'b1;
      end
   endgenerate

   always_comb begin
      chain_active = prev_full && !full_q;
      if (soft_rst)
         full_d = 1'b0;
      else if (sff_cmd && dev_sel && chain_active)
         full_d = 1'b1;
      else
         full_d = full_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q      <= 1'b0;
         casc_full_n <= 1'b1;
      end else begin
         full_q      <= full_d;
         casc_full_n <= !(full_d && prev_full);
      end
   end

   assign full_n = !full_q;

endmodule

// File: rtl/cam_rd_gate.sv
module cam_rd_gate #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] ds_q,
   input  logic [DW-1:0] pa_q,
   input  logic          match_in,
   output logic          rd_en_n
);

   localparam logic [DW-1:0] ALL_ONES = '1;

   logic own_page;
   logic bcast_hit;

   always_comb begin
      own_page  = (ds_q == pa_q);
      bcast_hit = (ds_q == ALL_ONES) && match_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_en_n <= 1'b1;
      else
         rd_en_n <= !(own_page || bcast_hit);
   end

endmodule

// File: rtl/cam_sel_ctrl.sv
module cam_sel_ctrl
   import cam_sel_pkg::*;
#(
   parameter int             DW         = 16,
   parameter int             OPW        = 8,
   parameter logic [OPW-1:0] OP_TARGET  = 'h02,
   parameter logic [OPW-1:0] OP_SETFULL = 'h07,
   parameter logic [DW-1:0]  PA_INIT    = '0,
   parameter bit             CHAIN_EN   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          cmd_n,
   input  logic          we_n,
   input  logic [DW-1:0] bus,
   input  logic          prev_full_n,
   input  logic          match_in,
   output logic          full_n,
   output logic          casc_full_n,
   output logic          rd_en_n
);

   generate
      if (DW < OPW + TGT_W + 1) begin : g_bad_width
         $error("cam_sel_ctrl: DW too small for opcode and target fields");
      end
      if (OP_TARGET == OP_SETFULL) begin : g_bad_opcode
         $error("cam_sel_ctrl: opcodes must differ");
      end
      if (PA_INIT == {DW{1'b1}}) begin : g_bad_page
         $error("cam_sel_ctrl: PA_INIT must not be all ones");
      end
   endgenerate

   logic          data_wr;
   logic          sff_cmd;
   tgt_e          tgt;
   logic [DW-1:0] ds_q;
   logic [DW-1:0] pa_q;
   logic          dev_sel;
   logic          soft_rst;
   logic          chain_active;

   cam_cmd_decode #(
      .DW(DW), .OPW(OPW), .OP_TARGET(OP_TARGET), .OP_SETFULL(OP_SETFULL)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cmd_n(cmd_n), .we_n(we_n),
      .bus(bus), .data_wr(data_wr), .sff_cmd(sff_cmd), .tgt(tgt)
   );

   cam_sel_regs #(
      .DW(DW), .PA_INIT(PA_INIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .tgt(tgt), .bus(bus),
      .chain_active(chain_active), .ds_q(ds_q), .pa_q(pa_q),
      .dev_sel(dev_sel), .soft_rst(soft_rst)
   );

   cam_full_chain #(
      .CHAIN_EN(CHAIN_EN)
   ) u_full (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .sff_cmd(sff_cmd),
      .dev_sel(dev_sel), .prev_full_n(prev_full_n),
      .chain_active(chain_active), .full_n(full_n), .casc_full_n(casc_full_n)
   );

   cam_rd_gate #(
      .DW(DW)
   ) u_rd (
      .clk(clk), .rst_n(rst_n), .ds_q(ds_q), .pa_q(pa_q),
      .match_in(match_in), .rd_en_n(rd_en_n)
   );

endmodule

// File: rtl/cam_sel_chk.sv
module cam_sel_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ce_n,
   input logic          match_in,
   input logic          full_n,
   input logic          casc_full_n,
   input logic          rd_en_n,
   input logic          dev_sel,
   input logic [DW-1:0] ds_q,
   input logic [DW-1:0] pa_q
);

   AST_PAGE_NOT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      pa_q != {DW{1'b1}});                                               // R4

   AST_CASC_NEEDS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      !casc_full_n |-> !full_n);                                         // R7

   AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n && !full_n) |=> !full_n);                                    // R9

   AST_IDLE_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n && full_n) |=> full_n);                                      // R2

   AST_DESELECT_HOLDS_DS: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_sel |=> $stable(ds_q));                                       // R3

   AST_OWN_PAGE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (ds_q == pa_q) |=> !rd_en_n);                                      // R8

   AST_BCAST_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      ((ds_q == {DW{1'b1}}) && !match_in) |=> rd_en_n);                  // R8

endmodule

bind cam_sel_ctrl cam_sel_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_cam_sel_ctrl.sv
module tb_cam_sel_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] W_CTRL = 16'h0200;
   localparam logic [15:0] W_DSEL = 16'h0201;
   localparam logic [15:0] W_PAGE = 16'h0202;
   localparam logic [15:0] W_SFF  = 16'h0700;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1;
   logic        cmd_n = 1'b1;
   logic        we_n = 1'b1;
   logic [15:0] bus = '0;
   logic        prev_full_n = 1'b1;
   logic        match_in = 1'b0;
   logic        full_n;
   logic        casc_full_n;
   logic        rd_en_n;

   cam_sel_ctrl dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cmd_n(cmd_n), .we_n(we_n),
      .bus(bus), .prev_full_n(prev_full_n), .match_in(match_in),
      .full_n(full_n), .casc_full_n(casc_full_n), .rd_en_n(rd_en_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // field: 0 = full_n, 1 = casc_full_n, 2 = rd_en_n
   typedef struct {
      int    field;
      logic  val;
      string tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   fails  = 0;
   bit   done   = 1'b0;

   task automatic expect_out(input int field, input logic val, input string tag);
      exp_t e;
      e.field = field;
      e.val   = val;
      e.tag   = tag;
      q.push_back(e);
   endtask

   always @(negedge clk) begin
      while (q.size() > 0) begin
         exp_t e;
         logic act;
         e = q.pop_front();
         act = (e.field == 0) ? full_n : (e.field == 1) ? casc_full_n : rd_en_n;
         checks++;
         if (act !== e.val) begin
            fails++;
            $display("FAIL %s field %0d actual %b expected %b", e.tag, e.field, act, e.val);
         end
      end
   end

   task automatic cyc(input logic c, input logic m, input logic w, input logic [15:0] d);
      @(negedge clk);
      ce_n = c; cmd_n = m; we_n = w; bus = d;
      @(posedge clk);
      #1;
      ce_n = 1'b1; cmd_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic cmdw(input logic [15:0] d);  cyc(1'b0, 1'b0, 1'b0, d); endtask
   task automatic dataw(input logic [15:0] d); cyc(1'b0, 1'b1, 1'b0, d); endtask
   task automatic idle();                      cyc(1'b1, 1'b1, 1'b1, 16'h0); endtask

   task automatic hw_reset(input string tag);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      expect_out(0, 1'b1, tag);
      expect_out(1, 1'b1, tag);
      expect_out(2, 1'b1, tag);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog (all requirements) actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      hw_reset("R1 reset state");
      // broadcast select opens reads only with a match
      match_in = 1'b1; idle();
      expect_out(2, 1'b0, "R8 broadcast with match");
      match_in = 1'b0; idle();
      expect_out(2, 1'b1, "R8 broadcast without match");
      // predecessor not full: set-full and page write refused
      cmdw(W_SFF);
      expect_out(0, 1'b1, "R5 set-full refused, predecessor empty");
      cmdw(W_PAGE); dataw(16'h0005);
      cmdw(W_DSEL); dataw(16'h0005); idle();
      expect_out(2, 1'b1, "R4 page write refused, predecessor empty");
      // now deselected (ds=5, pa=0)
      prev_full_n = 1'b0;
      cmdw(W_SFF);
      expect_out(0, 1'b1, "R3 deselected ignores set-full");
      match_in = 1'b1;
      cmdw(W_DSEL); dataw(16'hFFFF); idle(); idle();
      expect_out(2, 1'b1, "R3 deselected ignores select write");
      hw_reset("R1 reset while deselected");
      idle();
      expect_out(2, 1'b0, "R1 select word back to all ones");
      match_in = 1'b0;
      // all-ones page address rejected
      cmdw(W_PAGE); dataw(16'hFFFF);
      cmdw(W_DSEL); dataw(16'h0000); idle();
      expect_out(2, 1'b0, "R4 all-ones page rejected");
      // accepted page address
      cmdw(W_DSEL); dataw(16'hFFFF); idle();
      expect_out(2, 1'b1, "R8 broadcast, no match");
      cmdw(W_PAGE); dataw(16'h0003);
      cmdw(W_DSEL); dataw(16'h0003); idle();
      expect_out(2, 1'b0, "R4 page accepted, own-page read");
      cmdw(W_SFF);
      expect_out(0, 1'b0, "R5 set-full accepted");
      expect_out(1, 1'b0, "R7 cascade full with predecessor full");
      prev_full_n = 1'b1; idle();
      expect_out(1, 1'b1, "R7 cascade drops with predecessor");
      expect_out(0, 1'b0, "R9 full flag holds");
      prev_full_n = 1'b0; idle();
      expect_out(1, 1'b0, "R7 cascade returns");
      dataw(16'h0000);
      expect_out(0, 1'b0, "R2 data write without target ignored");
      cmdw(W_CTRL); idle(); dataw(16'h1234);
      expect_out(0, 1'b0, "R6 non-zero control write no effect");
      cmdw(W_CTRL); dataw(16'h0000);
      expect_out(0, 1'b1, "R6 control zero clears full");
      expect_out(1, 1'b1, "R6 cascade cleared");
      idle();
      expect_out(2, 1'b0, "R6 page and select kept");
      cyc(1'b1, 1'b0, 1'b0, W_SFF);
      expect_out(0, 1'b1, "R2 command with chip disabled ignored");
      cmdw(16'h0701);
      expect_out(0, 1'b1, "R5 malformed set-full ignored");
      cmdw(W_SFF);
      expect_out(0, 1'b0, "R5 set-full after soft reset");
      hw_reset("R1 reset clears full");
      match_in = 1'b1; idle();
      expect_out(2, 1'b0, "R1 broadcast restored after reset");
      expect_out(0, 1'b1, "R1 full stays clear");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule